// File: doc/BRIEF.md
# Delay-Line Tap Load Sequencer

This block programs a tap count into a delay line whose setting is controlled from software. It owns the delay line's control word. When it accepts a request with a 7-bit phase count, it makes three ordered writes to that word. The first write sets the force flag and puts in the new count, with the calibrate strobe low. The second write re-issues that word with the strobe raised. The block then samples a calibrate acknowledge input once per clock, up to a fixed limit, and stops at the first sample it finds high. The third write drops the strobe and leaves every other field alone.

The caller sees a one-cycle `done` pulse and a `timed_out` flag. The flag tells an acknowledged load apart from one that ran out of samples. Two single-write commands are available while the block is idle. One switches the software-tuning enable on. The other switches both the tuning enable and the force flag off, in one write.

Top module: `phase_tap_loader`

## Requirements
- R1: After reset, `ctl_word` is all zeros, and `ctl_wr`, `busy`, `done` and `timed_out` are low.
- R2: A `req_valid` taken while idle causes a write on the next edge (`ctl_wr` high). In that word, bits 19:13 hold `req_count`, bit 12 (force) is 1, bit 1 (calibrate strobe) is 0, and every other bit keeps its old value.
- R3: On the edge after the load write comes a second write. It carries the same word with bit 1 set.
- R4: `cal_ack` is sampled once per edge, starting on the edge after the strobe write. The first sample that reads 1 ends the poll.
- R5: If 1000 samples all read 0, the poll ends as a timeout. An acknowledge seen on sample 1000 still counts as acknowledged.
- R6: When the poll ends, the block writes the word once more with bit 1 cleared and the other bits kept. In the same cycle `done` pulses for one cycle, and `timed_out` is set to 1 for a timeout or 0 for an acknowledge. `timed_out` holds its value until the next `done`.
- R7: `busy` is high from the cycle after a request is accepted until `done`. A `req_valid` that arrives while busy is ignored.
- R8: A `tune_off` taken while idle makes one write that clears bit 12 and bit 20 and keeps the count field. A `tune_off` that arrives while busy is ignored.
- R9: A `tune_on` taken while idle makes one write that sets bit 20 (software-tuning enable).
- R10: If several commands arrive in the same idle cycle, `tune_off` wins over `tune_on`, and `tune_on` wins over `req_valid`. The commands that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request to load a tap count |
| req_count | input | 7 | Tap count to force |
| tune_on | input | 1 | Set the software-tuning enable |
| tune_off | input | 1 | Clear the force flag and the tuning enable |
| cal_ack | input | 1 | Calibrate status read back from the delay line |
| ctl_word | output | 32 | Delay-line control word |
| ctl_wr | output | 1 | One-cycle strobe for each write of `ctl_word` |
| busy | output | 1 | A load sequence is in progress |
| done | output | 1 | One-cycle pulse when a load sequence ends |
| timed_out | output | 1 | The last sequence ended without an acknowledge |

## Verification
The load sequence is driven with the acknowledge arriving on the first sample, on a mid-range sample, on exactly the last allowed sample, and never. Together these separate early exit, an off-by-one in the sample limit, and the timeout path, and each shows up as a different busy length and `timed_out` value. Extra commands are injected in the middle of a sequence to show that the write stream and the count field ignore them. Simultaneous idle commands expose the priority order.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_POLL = 2'd2
   } ptl_state_e;
endpackage

// File: rtl/ptl_poll_timer.sv
module ptl_poll_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CW'(LIMIT - 1));

   // R5
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && last));
endmodule

// File: rtl/ptl_word_fmt.sv
module ptl_word_fmt #(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 7,
   parameter int CNT_LSB   = 13,
   parameter int FORCE_BIT = 12,
   parameter int CAL_BIT   = 1,
   parameter int SWT_BIT   = 20
) (
   input  logic [WORD_W-1:0] cur,
   input  logic [CNT_W-1:0]  cnt,
   output logic [WORD_W-1:0] w_load,
   output logic [WORD_W-1:0] w_arm,
   output logic [WORD_W-1:0] w_clr,
   output logic [WORD_W-1:0] w_off,
   output logic [WORD_W-1:0] w_on
);
   localparam logic [WORD_W-1:0] ONE      = WORD_W'(1);
   localparam logic [WORD_W-1:0] CNT_MASK = ((ONE << CNT_W) - ONE) << CNT_LSB;
   localparam logic [WORD_W-1:0] F_MASK   = ONE << FORCE_BIT;
   localparam logic [WORD_W-1:0] C_MASK   = ONE << CAL_BIT;
   localparam logic [WORD_W-1:0] S_MASK   = ONE << SWT_BIT;

   logic [WORD_W-1:0] cnt_field;

   always_comb begin
      cnt_field = WORD_W'(cnt) << CNT_LSB;
      w_load    = (cur & ~CNT_MASK & ~C_MASK) | F_MASK | cnt_field;
      w_arm     = cur | C_MASK;
      w_clr     = cur & ~C_MASK;
      w_off     = cur & ~(F_MASK | S_MASK);
      w_on      = cur | S_MASK;
   end
endmodule

// File: rtl/phase_tap_loader.sv
module phase_tap_loader #(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 7,
   parameter int CNT_LSB   = 13,
   parameter int FORCE_BIT = 12,
   parameter int CAL_BIT   = 1,
   parameter int SWT_BIT   = 20,
   parameter int MAX_POLLS = 1000,
   parameter bit ACK_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CNT_W-1:0]  req_count,
   input  logic              tune_on,
   input  logic              tune_off,
   input  logic              cal_ack,
   output logic [WORD_W-1:0] ctl_word,
   output logic              ctl_wr,
   output logic              busy,
   output logic              done,
   output logic              timed_out
);
   import ptl_pkg::*;

   // elaboration-time parameter checks
   if (CNT_LSB + CNT_W > WORD_W) begin : g_bad_cnt
      $error("count field does not fit in the control word");
   end
   if (FORCE_BIT >= WORD_W || CAL_BIT >= WORD_W || SWT_BIT >= WORD_W) begin : g_bad_bit
      $error("a flag bit lies outside the control word");
   end
   if ((FORCE_BIT >= CNT_LSB && FORCE_BIT < CNT_LSB + CNT_W) ||
       (CAL_BIT   >= CNT_LSB && CAL_BIT   < CNT_LSB + CNT_W) ||
       (SWT_BIT   >= CNT_LSB && SWT_BIT   < CNT_LSB + CNT_W)) begin : g_bad_overlap
      $error("a flag bit overlaps the count field");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("MAX_POLLS must be at least one");
   end

   ptl_state_e        state;
   logic [WORD_W-1:0] w_load, w_arm, w_clr, w_off, w_on;
   logic              ack_s, tmr_last, exit_ack, exit_to, tmr_step;

   // acknowledge sampling variant
   if (ACK_REG) begin : g_ack_reg
      logic ack_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ack_q <= 1'b0;
         else        ack_q <= cal_ack;
      end
      assign ack_s = ack_q;
   end else begin : g_ack_direct
      assign ack_s = cal_ack;
   end

   ptl_word_fmt #(
      .WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
      .FORCE_BIT(FORCE_BIT), .CAL_BIT(CAL_BIT), .SWT_BIT(SWT_BIT)
   ) u_fmt (
      .cur(ctl_word), .cnt(req_count),
      .w_load(w_load), .w_arm(w_arm), .w_clr(w_clr), .w_off(w_off), .w_on(w_on)
   );

   assign exit_ack = (state == ST_POLL) && ack_s;
   assign exit_to  = (state == ST_POLL) && !ack_s && tmr_last;
   assign tmr_step = (state == ST_POLL) && !exit_ack && !exit_to;

   ptl_poll_timer #(.LIMIT(MAX_POLLS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(state == ST_ARM),
      .step(tmr_step), .last(tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ctl_word  <= '0;
         ctl_wr    <= 1'b0;
         done      <= 1'b0;
         timed_out <= 1'b0;
      end else begin
         ctl_wr <= 1'b0;
         done   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tune_off) begin
                  ctl_word <= w_off;
                  ctl_wr   <= 1'b1;
               end else if (tune_on) begin
                  ctl_word <= w_on;
                  ctl_wr   <= 1'b1;
               end else if (req_valid) begin
                  ctl_word <= w_load;
                  ctl_wr   <= 1'b1;
                  state    <= ST_ARM;
               end
            end
            ST_ARM: begin
               ctl_word <= w_arm;
               ctl_wr   <= 1'b1;
               state    <= ST_POLL;
            end
            ST_POLL: begin
               if (exit_ack || exit_to) begin
                  ctl_word  <= w_clr;
                  ctl_wr    <= 1'b1;
                  done      <= 1'b1;
                  timed_out <= exit_to;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   // R2
   load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && !tune_on && !tune_off) |=>
         (ctl_wr && ctl_word[FORCE_BIT] && !ctl_word[CAL_BIT] && busy));
   // R3
   arm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARM) |=> (ctl_wr && ctl_word[CAL_BIT]));
   // R6
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctl_wr && !ctl_word[CAL_BIT] && !busy));
   // R7
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
   // R8
   disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tune_off) |=>
         (ctl_wr && !ctl_word[FORCE_BIT] && !ctl_word[SWT_BIT]));
   // R5
   timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POLL && !ack_s && tmr_last) |=> (done && timed_out));
endmodule

// File: tb/phase_tap_loader_bench.sv
module phase_tap_loader_bench;
   localparam int FB = 12, CB = 1, SB = 20, LSB = 13, LIM = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [6:0]  req_count = '0;
   logic        tune_on = 1'b0, tune_off = 1'b0, cal_ack = 1'b0;
   logic [31:0] ctl_word;
   logic        ctl_wr, busy, done, timed_out;

   int checks = 0, failures = 0;
   int ack_at = 0;
   bit finished = 1'b0;

   // reference model state
   int          m_state = 0;
   int          m_cnt = 0;
   logic [31:0] m_word = '0;
   logic        m_wr = 0, m_done = 0, m_to = 0;

   always #2 clk = ~clk;

   phase_tap_loader u_phase_tap_loader (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
      .tune_on(tune_on), .tune_off(tune_off), .cal_ack(cal_ack),
      .ctl_word(ctl_word), .ctl_wr(ctl_wr), .busy(busy), .done(done),
      .timed_out(timed_out)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_word = '0; m_wr = 0; m_done = 0; m_to = 0;
      end else begin
         m_wr = 0; m_done = 0;
         if (m_state == 0) begin
            if (tune_off) begin
               m_word[FB] = 0; m_word[SB] = 0; m_wr = 1;
            end else if (tune_on) begin
               m_word[SB] = 1; m_wr = 1;
            end else if (req_valid) begin
               m_word[LSB+:7] = req_count; m_word[FB] = 1; m_word[CB] = 0;
               m_wr = 1; m_state = 1;
            end
         end else if (m_state == 1) begin
            m_word[CB] = 1; m_wr = 1; m_state = 2; m_cnt = 0;
         end else begin
            m_cnt++;
            if (cal_ack || m_cnt == LIM) begin
               m_to = !cal_ack; m_word[CB] = 0; m_wr = 1; m_done = 1; m_state = 0;
            end
         end
      end
   end

   // acknowledge stimulus: high from sample number ack_at onward
   always @(negedge clk)
      cal_ack <= (ack_at > 0) && (m_state == 2) && (m_cnt + 1 >= ack_at);

   // per-cycle comparison with the model
   always @(negedge clk) if (rst_n && !finished) begin
      chk(ctl_word[LSB+:7] == m_word[LSB+:7], "R2 count field", ctl_word[LSB+:7], m_word[LSB+:7]);
      chk(ctl_word[FB] == m_word[FB], "R2 force bit", ctl_word[FB], m_word[FB]);
      chk(ctl_word[CB] == m_word[CB], "R3 strobe bit", ctl_word[CB], m_word[CB]);
      chk(ctl_word[SB] == m_word[SB], "R9 tuning bit", ctl_word[SB], m_word[SB]);
      chk(ctl_wr == m_wr, "R6 write strobe", ctl_wr, m_wr);
      chk(busy == (m_state != 0), "R7 busy", busy, m_state != 0);
      chk(done == m_done, "R6 done", done, m_done);
      chk(timed_out == m_to, "R5 timed_out", timed_out, m_to);
   end

   task automatic run_seq(input logic [6:0] c, input int at, input int inj,
                          output int writes, output int bcyc);
      ack_at = at;
      @(negedge clk); req_valid = 1; req_count = c;
      @(negedge clk); req_valid = 0;
      writes = 0; bcyc = 0;
      forever begin
         if (ctl_wr) writes++;
         if (busy) bcyc++;
         if (done) break;
         if (bcyc == 2 && inj == 1) begin req_valid = 1; req_count = 7'h11; end
         if (bcyc == 2 && inj == 2) tune_off = 1;
         if (bcyc == 3) begin req_valid = 0; tune_off = 0; end
         @(negedge clk);
      end
      ack_at = 0;
      @(negedge clk);
   endtask

   initial begin
      int w, b;
      repeat (3) @(negedge clk);
      // R1
      chk(ctl_word == 0 && !ctl_wr && !busy && !done && !timed_out, "R1 reset state",
          {ctl_word, ctl_wr, busy, done, timed_out}, 0);
      rst_n = 1;
      @(negedge clk);
      tune_on = 1; @(negedge clk); tune_on = 0;
      chk(ctl_word[SB] == 1, "R9 tuning enable set", ctl_word[SB], 1);
      @(negedge clk);

      run_seq(7'h55, 3, 0, w, b);
      chk(w == 3, "R3 three writes per load", w, 3);
      chk(b == 4, "R4 busy length ack on sample 3", b, 4);
      chk(ctl_word[LSB+:7] == 7'h55 && ctl_word[FB] && !ctl_word[CB] && ctl_word[SB],
          "R2 final word after load", ctl_word, 32'h001ab000 | (1 << FB) | (1 << SB));
      chk(!timed_out, "R6 acknowledged load", timed_out, 0);

      run_seq(7'h2a, 5, 1, w, b);
      chk(ctl_word[LSB+:7] == 7'h2a, "R7 busy request ignored", ctl_word[LSB+:7], 7'h2a);
      chk(w == 3 && !busy, "R7 no extra sequence", w, 3);

      run_seq(7'h01, 1, 0, w, b);
      chk(b == 2, "R4 immediate acknowledge", b, 2);

      run_seq(7'h7f, 0, 0, w, b);
      chk(timed_out == 1, "R5 timeout flagged", timed_out, 1);
      chk(b == LIM + 1, "R5 timeout after limit samples", b, LIM + 1);
      chk(ctl_word[CB] == 0, "R6 strobe cleared after timeout", ctl_word[CB], 0);

      run_seq(7'h33, LIM, 2, w, b);
      chk(timed_out == 0, "R5 acknowledge on last sample", timed_out, 0);
      chk(b == LIM + 1, "R5 last-sample busy length", b, LIM + 1);
      chk(ctl_word[FB] == 1 && ctl_word[SB] == 1, "R8 busy disable ignored",
          {ctl_word[FB], ctl_word[SB]}, 2'b11);

      tune_off = 1; @(negedge clk); tune_off = 0;
      chk(!ctl_word[FB] && !ctl_word[SB] && ctl_word[LSB+:7] == 7'h33,
          "R8 disable clears flags keeps count", ctl_word, 32'h00066000);

      tune_off = 1; tune_on = 1; req_valid = 1; req_count = 7'h05;
      @(negedge clk); tune_off = 0; tune_on = 0; req_valid = 0;
      chk(!busy && !ctl_word[SB] && ctl_word[LSB+:7] == 7'h33, "R10 disable wins",
          {busy, ctl_word[SB]}, 0);
      @(negedge clk);
      tune_on = 1; req_valid = 1;
      @(negedge clk); tune_on = 0; req_valid = 0;
      chk(!busy && ctl_word[SB], "R10 enable wins over request", {busy, ctl_word[SB]}, 1);
      repeat (3) @(negedge clk);
      chk(!busy && ctl_word[LSB+:7] == 7'h33, "R10 request dropped", ctl_word[LSB+:7], 7'h33);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule